// File: doc/BRIEF.md
# Data Watchpoint Match Unit

This block holds one programmable data watchpoint. Software writes an address register and a control register through a small register port. Each memory access is presented on an access stream with its address, the byte lanes it touches, its kind, its privilege, its security state and the result of the exclusive-monitor check. When the watchpoint is enabled and every qualifier in the control register agrees with the access, the block raises a registered hit one clock later.

The access stream uses valid/ready. The block never applies back-pressure: `acc_ready` is held high, so every cycle with `acc_valid` high is an accepted access. The register port and the hit output are plain signals.

The control register is 16 bits wide. Bit 0 is the enable. Bits [2:1] select privilege. Bits [4:3] select the access kind. Bits [8:5] are the byte-lane select, with bit 5 standing for lane 0. Bits [15:14] select the security state. All other bits are reserved.

Top module: `wpt_match_unit`

## Requirements
- R1: After reset both registers read 0, `wp_hit` is low and `acc_ready` is high. While control bit 0 (enable) is 0, `wp_hit` never rises.
- R2: Control bits [15:14] qualify the security state, with `acc_nonsec`=1 meaning Non-secure. 00 matches either state, 01 matches only Non-secure accesses and 10 matches only Secure accesses.
- R3: Control bits [8:5] select byte lanes, with bit 5+i standing for lane i. A hit requires at least one lane that is set both in `acc_lanes` and in this field.
- R4: Control bits [4:3] qualify the access kind. 01 matches loads, 10 matches stores and 11 matches both. `acc_kind` is encoded as 0 load, 1 store, 2 swap, 3 load-exclusive and 4 store-exclusive. Codes 5 to 7 never hit.
- R5: A swap counts as both a load and a store, so it hits under kind setting 01, 10 or 11.
- R6: A load-exclusive hits under kind setting 01 or 11. A store-exclusive hits under 10 or 11, and only when `acc_mon_ok` is 1.
- R7: Control bits [2:1] qualify the privilege of the access, with `acc_priv`=1 meaning privileged. 01 matches privileged accesses only, 10 matches unprivileged accesses only and 11 matches both.
- R8: A reserved encoding never hits. The reserved encodings are security 11, kind 00 and privilege 00.
- R9: Control bits [13:9] and [31:16] read as zero, and writes to them are ignored. Address register bits [1:0] read as zero. `reg_sel`=0 selects the address register and `reg_sel`=1 selects the control register. `reg_rdata` shows the selected register combinationally.
- R10: The address compare uses bits [31:2] only. Access address bits [1:0] do not affect the compare.
- R11: `wp_hit` is high in the cycle after an accepted access whose qualifiers all match. It is low after any cycle without `acc_valid`.
- R12: A register write takes effect for accesses presented from the next cycle onward. An access presented in the same cycle as the write is judged against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 address, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Access valid |
| acc_ready | output | 1 | Access ready (always 1) |
| acc_addr | input | 32 | Access byte address |
| acc_lanes | input | 4 | Byte lanes touched by the access |
| acc_kind | input | 3 | Access kind code |
| acc_priv | input | 1 | 1 = privileged access |
| acc_nonsec | input | 1 | 1 = Non-secure access |
| acc_mon_ok | input | 1 | Exclusive-monitor check passed |
| wp_hit | output | 1 | Registered watchpoint hit |

## Verification
The hardest case to reach is a store-exclusive under a kind setting that accepts stores, but combined with every security and privilege setting and with reserved codes in other fields. A miss there is easy to blame on the wrong qualifier. The bench therefore sweeps every combination of security, kind, privilege and enable settings against every access kind, privilege, security state and monitor flag. It also varies the lanes on each access, and predicts every hit arithmetically. A second case is a write in the same cycle as an access. The bench drives both on one edge and expects the hit from the old settings.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int LANES  = 4;
  localparam int LSB    = $clog2(LANES);
  localparam int CTRL_W = 16;

  typedef enum logic [2:0] {
    K_LOAD  = 3'd0,
    K_STORE = 3'd1,
    K_SWAP  = 3'd2,
    K_LDEX  = 3'd3,
    K_STEX  = 3'd4
  } acc_kind_e;

  typedef struct packed {
    logic [1:0]       sec;
    logic [4:0]       rsv;
    logic [LANES-1:0] lanes;
    logic [1:0]       kind;
    logic [1:0]       priv;
    logic             en;
  } wctl_t;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'hC1FF;
endpackage

// File: rtl/wpt_regs.sv
module wpt_regs
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  sel,
  input  logic [ADDR_W-1:0]     wdata,
  output logic [ADDR_W-1:0]     rdata,
  output logic [ADDR_W-1:LSB]   addr_q,
  output wctl_t                 ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (sel) ctrl_q <= wctl_t'(wdata[CTRL_W-1:0] & CTRL_WMASK);
      else     addr_q <= wdata[ADDR_W-1:LSB];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) rdata[CTRL_W-1:0] = ctrl_q;
    else     rdata[ADDR_W-1:LSB] = addr_q;
  end
endmodule

// File: rtl/wpt_qual.sv
module wpt_qual
  import wpt_pkg::*;
(
  input  wctl_t            ctrl,
  input  logic [LANES-1:0] lanes,
  input  logic [2:0]       kind,
  input  logic             priv,
  input  logic             nonsec,
  input  logic             mon_ok,
  output logic             ok
);
  logic [LANES-1:0] lane_and;
  logic sec_ok, priv_ok, kind_ok, lane_ok, ld_m, st_m;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_and[i] = lanes[i] & ctrl.lanes[i];
  end
  assign lane_ok = |lane_and;

  always_comb begin
    unique case (ctrl.sec)
      2'b00:   sec_ok = 1'b1;
      2'b01:   sec_ok = nonsec;
      2'b10:   sec_ok = !nonsec;
      default: sec_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (ctrl.priv)
      2'b01:   priv_ok = priv;
      2'b10:   priv_ok = !priv;
      2'b11:   priv_ok = 1'b1;
      default: priv_ok = 1'b0;
    endcase
  end

  assign ld_m = ctrl.kind[0];
  assign st_m = ctrl.kind[1];

  always_comb begin
    case (kind)
      K_LOAD:  kind_ok = ld_m;
      K_STORE: kind_ok = st_m;
      K_SWAP:  kind_ok = ld_m | st_m;
      K_LDEX:  kind_ok = ld_m;
      K_STEX:  kind_ok = st_m & mon_ok;
      default: kind_ok = 1'b0;
    endcase
  end

  assign ok = sec_ok & priv_ok & kind_ok & lane_ok;
endmodule

// File: rtl/wpt_match_unit.sv
module wpt_match_unit
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LANES-1:0]  acc_lanes,
  input  logic [2:0]        acc_kind,
  input  logic              acc_priv,
  input  logic              acc_nonsec,
  input  logic              acc_mon_ok,
  output logic              wp_hit
);
  logic [ADDR_W-1:LSB] addr_q;
  wctl_t               ctrl_q;
  logic                qual_ok, addr_eq, hit_d, hit_q;

  wpt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .addr_q (addr_q),
    .ctrl_q (ctrl_q)
  );

  wpt_qual u_qual (
    .ctrl   (ctrl_q),
    .lanes  (acc_lanes),
    .kind   (acc_kind),
    .priv   (acc_priv),
    .nonsec (acc_nonsec),
    .mon_ok (acc_mon_ok),
    .ok     (qual_ok)
  );

  assign acc_ready = 1'b1;
  assign addr_eq   = (acc_addr[ADDR_W-1:LSB] == addr_q);
  assign hit_d     = acc_valid & acc_ready & ctrl_q.en & addr_eq & qual_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign wp_hit = hit_q;
endmodule

// File: rtl/wpt_match_chk.sv
module wpt_match_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              ctrl_en,
  input logic [1:0]        ctrl_sec,
  input logic [1:0]        ctrl_kind,
  input logic [1:0]        ctrl_priv,
  input logic              reg_sel,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic              wp_hit
);
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !wp_hit); // R1
  AST_SEC_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sec == 2'b11) |=> !wp_hit); // R8
  AST_KIND_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_kind == 2'b00) |=> !wp_hit); // R8
  AST_PRIV_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_priv == 2'b00) |=> !wp_hit); // R8
  AST_HIT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !wp_hit); // R11
  AST_CTRL_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[13:9] == 5'd0 && reg_rdata[ADDR_W-1:16] == '0)); // R9
  AST_ADDR_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[1:0] == 2'd0)); // R9
endmodule

bind wpt_match_unit wpt_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .ctrl_en   (ctrl_q.en),
  .ctrl_sec  (ctrl_q.sec),
  .ctrl_kind (ctrl_q.kind),
  .ctrl_priv (ctrl_q.priv),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .wp_hit    (wp_hit)
);

// File: tb/test_wpt_match_unit.sv
`timescale 1ns/1ps
module test_wpt_match_unit;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr_en = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        acc_valid = 0, acc_ready;
  logic [31:0] acc_addr = 0;
  logic [3:0]  acc_lanes = 0;
  logic [2:0]  acc_kind = 0;
  logic        acc_priv = 0, acc_nonsec = 0, acc_mon_ok = 0;
  logic        wp_hit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wpt_match_unit i_wpt_match_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_lanes(acc_lanes),
    .acc_kind(acc_kind), .acc_priv(acc_priv), .acc_nonsec(acc_nonsec),
    .acc_mon_ok(acc_mon_ok), .wp_hit(wp_hit));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected hit, computed from the requirement text
  function automatic bit model(logic [15:0] c, bit amatch, logic [3:0] ln,
                               int k, bit pr, bit ns, bit mon);
    bit s_ok, p_ok, k_ok, ldm, stm;
    s_ok = (c[15:14] == 0) || (c[15:14] == 1 && ns) || (c[15:14] == 2 && !ns);
    p_ok = (c[2:1] == 3) || (c[2:1] == 1 && pr) || (c[2:1] == 2 && !pr);
    ldm = c[3]; stm = c[4];
    case (k)
      0: k_ok = ldm;
      1: k_ok = stm;
      2: k_ok = ldm || stm;
      3: k_ok = ldm;
      4: k_ok = stm && mon;
      default: k_ok = 0;
    endcase
    return c[0] && amatch && ((ln & c[8:5]) != 0) && s_ok && p_ok && k_ok;
  endfunction

  task automatic wr(bit sel, logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr_en = 1;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(string req, bit sel, logic [31:0] exp);
    reg_sel = sel; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic acc(string req, logic [31:0] a, logic [3:0] ln, int k,
                     bit pr, bit ns, bit mon, bit exp);
    acc_valid = 1; acc_addr = a; acc_lanes = ln; acc_kind = 3'(k);
    acc_priv = pr; acc_nonsec = ns; acc_mon_ok = mon;
    @(negedge clk);
    acc_valid = 0;
    chk(req, {31'd0, wp_hit}, {31'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    int idx;
    bit e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1", 0, 32'h0);
    rd("R1", 1, 32'h0);
    chk("R1", {31'd0, wp_hit}, 0);
    chk("R1", {31'd0, acc_ready}, 1);

    // R9 reserved bits and address low bits
    wr(1, 32'hFFFF_FFFF);
    rd("R9", 1, 32'h0000_C1FF);
    wr(0, 32'h8000_1007);
    rd("R9", 0, 32'h8000_1004);

    // R10 address compare on bits [31:2]
    wr(1, 32'h0000_01FF);
    acc("R10", 32'h8000_1004, 4'hF, 0, 1, 0, 0, 1);
    acc("R10", 32'h8000_1007, 4'hF, 1, 0, 1, 0, 1);
    acc("R10", 32'h8000_1000, 4'hF, 0, 1, 0, 0, 0);
    acc("R10", 32'h0000_1004, 4'hF, 0, 1, 0, 0, 0);

    // R11 idle cycles give no hit
    acc("R11", 32'h8000_1004, 4'hF, 0, 1, 0, 0, 1);
    @(negedge clk);
    chk("R11", {31'd0, wp_hit}, 0);
    acc_valid = 0; acc_addr = 32'h8000_1004; acc_lanes = 4'hF;
    @(negedge clk);
    chk("R11", {31'd0, wp_hit}, 0);

    // R12 write in the same cycle as an access uses old settings
    reg_sel = 1; reg_wdata = 32'h0; reg_wr_en = 1;
    acc("R12", 32'h8000_1004, 4'hF, 0, 1, 0, 0, 1);
    reg_wr_en = 0;
    acc("R12", 32'h8000_1004, 4'hF, 0, 1, 0, 0, 0);

    // R3 byte-lane sweep
    for (int b = 0; b < 16; b++) begin
      wr(1, {16'd0, 2'b00, 5'd0, 4'(b), 2'b11, 2'b11, 1'b1});
      for (int l = 0; l < 16; l++) begin
        e = (b & l) != 0;
        acc("R3", 32'h8000_1004, 4'(l), 2, 0, 1, 1, e);
      end
    end

    // R1 R2 R4 R5 R6 R7 R8 qualifier sweep; reserved bits written as ones
    idx = 0;
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
        for (int p = 0; p < 4; p++)
          for (int en = 0; en < 2; en++) begin
            c = {2'(s), 5'b11111, 4'b0110, 2'(t), 2'(p), 1'(en)};
            wr(1, {16'hFFFF, c});
            rd("R9", 1, {16'd0, c & 16'hC1FF});
            for (int k = 0; k < 6; k++)
              for (int pr = 0; pr < 2; pr++)
                for (int ns = 0; ns < 2; ns++)
                  for (int mon = 0; mon < 2; mon++) begin
                    logic [3:0] ln;
                    ln = 4'(idx % 16);
                    idx++;
                    e = model(c, 1, ln, k, 1'(pr), 1'(ns), 1'(mon));
                    if (en == 0) acc("R1", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                    else if (s == 3 || t == 0 || p == 0)
                      acc("R8", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                    else if (k == 2) acc("R5", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                    else if (k >= 3 && k <= 4)
                      acc("R6", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                    else if (k == 5) acc("R4", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                    else if (s != 0) acc("R2", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                    else if (p != 3) acc("R7", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                    else acc("R4", 32'h8000_1004, ln, k, 1'(pr), 1'(ns), 1'(mon), e);
                  end
          end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule